// File: doc/BRIEF.md
# VGA Frame Sync Timing Generator

This block generates the timing skeleton of a raster video frame. A single axis engine counts an active window, a front porch, a sync pulse and a back porch. It drives an active-low sync line, a blanking flag and the current position on that axis. It also emits a one-clock strobe on the clock edge where its sync pulse begins.

Two copies of the engine make up a frame. The horizontal copy advances on a pixel enable taken from a clock divider. The vertical copy advances only when the horizontal strobe is high, so it counts lines. The vertical strobe serves as an end-of-frame marker that a pixel source can use to restart its fetch.

The defaults give the common 640x480 frame at 60 Hz. A 100 MHz clock divided by 4 yields a 25 MHz pixel rate. Each line has 640 active, 16 front-porch, 96 sync and 48 back-porch pixels. Each frame has 480 active, 10 front-porch, 2 sync and 33 back-porch lines.

Top module: `vga_frame_timer`

## Requirements
- R1: While `rst` (active high, asynchronous) is high, the following hold without any clock edge: `hsync_n` = 1, `vsync_n` = 1, `hblank` = 0, `vblank` = 0, `h_pos` = 0, `v_pos` = 0, `line_strobe` = 0 and `eof` = 0.
- R2: `h_pos` only ever steps by +1. From H_ACTIVE+H_FRONT+H_SYNC+H_BACK-1 it wraps to 0, and it never leaves that range.
- R3: `h_pos` advances exactly once every CLK_DIV clock cycles.
- R4: `hblank` is 1 exactly when `h_pos` >= H_ACTIVE. This covers the front porch, sync and back porch, so one blanking interval lasts (H_FRONT+H_SYNC+H_BACK)*CLK_DIV clocks.
- R5: `hsync_n` is 0 exactly when `h_pos` lies in [H_ACTIVE+H_FRONT, H_ACTIVE+H_FRONT+H_SYNC). Each low pulse lasts H_SYNC*CLK_DIV clocks. Pulses recur every line period of H_TOTAL*CLK_DIV clocks and start H_FRONT*CLK_DIV clocks after `hblank` rises.
- R6: `line_strobe` is high for exactly one clock. It rises on the same edge where `hsync_n` falls, and it is high on every such edge.
- R7: `v_pos` changes only on the clock after a `line_strobe` cycle. It steps by +1 and wraps from V_TOTAL-1 to 0.
- R8: `vblank` is 1 exactly when `v_pos` >= V_ACTIVE. `vsync_n` is 0 exactly when `v_pos` lies in [V_ACTIVE+V_FRONT, V_ACTIVE+V_FRONT+V_SYNC), a window of V_SYNC line periods. The `vsync_n` pulse starts V_FRONT line periods after `vblank` rises.
- R9: `eof` is high for exactly one clock, on the edge where `vsync_n` falls. It recurs every V_TOTAL line periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Asynchronous reset, active high; release is synchronized internally |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| hblank | output | 1 | High outside the active part of a line |
| vblank | output | 1 | High outside the active lines of a frame |
| h_pos | output | $clog2(H_TOTAL) | Pixel position within the line, 0 at the first active pixel |
| v_pos | output | $clog2(V_TOTAL) | Line position within the frame, 0 at the first active line |
| line_strobe | output | 1 | One-clock pulse at the start of each horizontal sync |
| eof | output | 1 | One-clock pulse at the start of each vertical sync |

## Verification
The assertions assume that every axis parameter is positive and that the back porch is at least one count. Under that assumption the sync window ends before the wrap. They also assume that `rst` is released long enough before the first edge they sample, so that `$past` sees reset-state values. The bench uses a reduced frame of 15 pixels by 8 lines with a divide of 2, which meets these conditions. It asserts and releases `rst` only between clock edges, and it restarts its edge-interval measurements after each reset.

// File: rtl/vga_tim_pkg.sv
package vga_tim_pkg;

  // Phase of one sync axis, in the order the counter walks through them.
  typedef enum logic [1:0] {
    SEG_ACTIVE = 2'd0,
    SEG_FRONT  = 2'd1,
    SEG_SYNC   = 2'd2,
    SEG_BACK   = 2'd3
  } seg_e;

  // Flags registered together on every counter update.
  typedef struct packed {
    logic blank;
    logic sync;
    logic gate;
  } axis_flags_t;

endpackage

// File: rtl/vga_rst_sync.sv
module vga_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // Assert immediately, release on the clock.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/vga_pix_div.sv
module vga_pix_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV > 1) begin : g_div
      localparam int DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);

      logic [DW-1:0] cnt_q;
      logic [DW-1:0] cnt_d;

      always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick = (cnt_q == LAST);
    end else begin : g_nodiv
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/vga_axis_gen.sv
module vga_axis_gen
  import vga_tim_pkg::*;
#(
  parameter int ACTIVE = 640,
  parameter int FRONT  = 16,
  parameter int PULSE  = 96,
  parameter int BACK   = 48,
  localparam int TOTAL = ACTIVE + FRONT + PULSE + BACK,
  localparam int CW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  output logic [CW-1:0] pos,
  output logic          blank,
  output logic          sync_n,
  output logic          gate
);

  localparam int SYNC_START = ACTIVE + FRONT;
  localparam int SYNC_END   = SYNC_START + PULSE;
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  seg_e          seg_q, seg_d;
  axis_flags_t   flg_q, flg_d;

  function automatic seg_e seg_of(input logic [CW-1:0] c);
    int v;
    v = int'(c);
    if (v < ACTIVE)          return SEG_ACTIVE;
    else if (v < SYNC_START) return SEG_FRONT;
    else if (v < SYNC_END)   return SEG_SYNC;
    else                     return SEG_BACK;
  endfunction

  // Next state: counter and the flags that belong to its new value.
  always_comb begin
    cnt_d = cnt_q;
    if (ce) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
    seg_d       = seg_of(cnt_d);
    flg_d.blank = (seg_d != SEG_ACTIVE);
    flg_d.sync  = (seg_d == SEG_SYNC);
    flg_d.gate  = ce && (seg_d == SEG_SYNC) && (seg_q != SEG_SYNC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      seg_q <= SEG_ACTIVE;
      flg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      seg_q <= seg_d;
      flg_q <= flg_d;
    end
  end

  assign pos    = cnt_q;
  assign blank  = flg_q.blank;
  assign sync_n = ~flg_q.sync;
  assign gate   = flg_q.gate;

endmodule

// File: rtl/vga_frame_timer.sv
module vga_frame_timer #(
  parameter int CLK_DIV  = 4,
  parameter int H_ACTIVE = 640,
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BACK   = 33,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          hblank,
  output logic          vblank,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          line_strobe,
  output logic          eof
);

  logic core_rst_n;
  logic pix_ce;
  logic h_gate;

  vga_rst_sync #(.STAGES(2)) u_rst (
    .clk  (clk),
    .rst  (rst),
    .rst_n(core_rst_n)
  );

  vga_pix_div #(.DIV(CLK_DIV)) u_div (
    .clk  (clk),
    .rst_n(core_rst_n),
    .tick (pix_ce)
  );

  vga_axis_gen #(
    .ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .PULSE(H_SYNC), .BACK(H_BACK)
  ) u_h (
    .clk   (clk),
    .rst_n (core_rst_n),
    .ce    (pix_ce),
    .pos   (h_pos),
    .blank (hblank),
    .sync_n(hsync_n),
    .gate  (h_gate)
  );

  // Vertical axis counts lines: its enable is the horizontal gate.
  vga_axis_gen #(
    .ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .PULSE(V_SYNC), .BACK(V_BACK)
  ) u_v (
    .clk   (clk),
    .rst_n (core_rst_n),
    .ce    (h_gate),
    .pos   (v_pos),
    .blank (vblank),
    .sync_n(vsync_n),
    .gate  (eof)
  );

  assign line_strobe = h_gate;

endmodule

// File: rtl/vga_frame_timer_chk.sv
module vga_frame_timer_chk #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  parameter int HW      = 10,
  parameter int VW      = 10
) (
  input logic          clk,
  input logic          core_rst_n,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          hblank,
  input logic          vblank,
  input logic [HW-1:0] h_pos,
  input logic [VW-1:0] v_pos,
  input logic          line_strobe,
  input logic          eof
);

  p_hpos_range_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    int'(h_pos) < H_TOTAL);

  p_hpos_step_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (h_pos != $past(h_pos)) |->
      (h_pos == (($past(h_pos) == HW'(H_TOTAL - 1)) ? '0 : HW'($past(h_pos) + 1'b1))));

  p_sync_in_blank_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    !hsync_n |-> hblank);

  p_gate_single_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    line_strobe |=> !line_strobe);

  p_gate_edge_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    line_strobe |-> $fell(hsync_n));

  p_vpos_hold_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    !$stable(v_pos) |-> $past(line_strobe));

  p_vsync_in_blank_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    !vsync_n |-> vblank);

  p_eof_edge_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    eof |-> $fell(vsync_n));

  p_eof_single_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    eof |=> !eof);

  p_vpos_range_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    int'(v_pos) < V_TOTAL);

endmodule

bind vga_frame_timer vga_frame_timer_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .hsync_n    (hsync_n),
  .vsync_n    (vsync_n),
  .hblank     (hblank),
  .vblank     (vblank),
  .h_pos      (h_pos),
  .v_pos      (v_pos),
  .line_strobe(line_strobe),
  .eof        (eof)
);

// File: tb/vga_frame_timer_test.sv
module vga_frame_timer_test;

  localparam int DIV = 2;
  localparam int HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);
  localparam int LINE  = HT * DIV;
  localparam int FRAME = LINE * VT;

  logic clk = 1'b0;
  logic rst;
  logic hsync_n, vsync_n, hblank, vblank, line_strobe, eof;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_pos;

  always #4 clk = ~clk;

  vga_frame_timer #(
    .CLK_DIV(DIV),
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
  ) uut (
    .clk(clk), .rst(rst),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .hblank(hblank), .vblank(vblank),
    .h_pos(h_pos), .v_pos(v_pos),
    .line_strobe(line_strobe), .eof(eof)
  );

  int vec = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor state
  bit mon_on = 0;
  bit fresh  = 1;
  int cyc = 0;
  int n_eof = 0;
  logic p_hs, p_vs, p_hb, p_vb, p_ls, p_eof;
  int p_hp, p_vp;
  int t_hs_fall, t_hb_rise, t_hp_chg, t_vs_fall, t_vb_rise;

  task automatic clear_marks();
    t_hs_fall = -1; t_hb_rise = -1; t_hp_chg = -1;
    t_vs_fall = -1; t_vb_rise = -1;
    fresh = 1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      int hp, vp;
      hp = int'(h_pos);
      vp = int'(v_pos);
      // Level relations against position (R4, R5, R8, R2 range)
      chk("R2 range", int'(hp < HT), 1);
      chk("R4 hblank", int'(hblank), int'(hp >= HA));
      chk("R5 hsync level", int'(!hsync_n), int'(hp >= HA + HF && hp < HA + HF + HS));
      chk("R8 vblank", int'(vblank), int'(vp >= VA));
      chk("R8 vsync level", int'(!vsync_n), int'(vp >= VA + VF && vp < VA + VF + VS));
      if (!fresh) begin
        // R2/R3 horizontal stepping
        if (hp != p_hp) begin
          chk("R2 step", hp, (p_hp == HT - 1) ? 0 : p_hp + 1);
          if (t_hp_chg >= 0) chk("R3 spacing", cyc - t_hp_chg, DIV);
          t_hp_chg = cyc;
        end
        // hblank edges (R4)
        if (hblank && !p_hb) t_hb_rise = cyc;
        if (!hblank && p_hb && t_hb_rise >= 0)
          chk("R4 blank width", cyc - t_hb_rise, (HF + HS + HB) * DIV);
        // hsync edges (R5, R6)
        if (!hsync_n && p_hs) begin
          chk("R6 strobe at hsync fall", int'(line_strobe), 1);
          if (t_hs_fall >= 0) chk("R5 line period", cyc - t_hs_fall, LINE);
          if (t_hb_rise >= 0) chk("R5 front porch", cyc - t_hb_rise, HF * DIV);
          t_hs_fall = cyc;
        end
        if (hsync_n && !p_hs && t_hs_fall >= 0)
          chk("R5 sync width", cyc - t_hs_fall, HS * DIV);
        if (line_strobe) chk("R6 strobe coincident", int'(!hsync_n && p_hs), 1);
        if (p_ls) chk("R6 strobe one clock", int'(line_strobe), 0);
        // R7 vertical stepping
        if (vp != p_vp) begin
          chk("R7 step after strobe", int'(p_ls), 1);
          chk("R7 step", vp, (p_vp == VT - 1) ? 0 : p_vp + 1);
        end
        // vblank / vsync edges (R8, R9)
        if (vblank && !p_vb) t_vb_rise = cyc;
        if (!vblank && p_vb && t_vb_rise >= 0)
          chk("R8 vblank width", cyc - t_vb_rise, (VF + VS + VB) * LINE);
        if (!vsync_n && p_vs) begin
          chk("R9 eof at vsync fall", int'(eof), 1);
          if (t_vs_fall >= 0) chk("R9 frame period", cyc - t_vs_fall, FRAME);
          if (t_vb_rise >= 0) chk("R8 vfront porch", cyc - t_vb_rise, VF * LINE);
          t_vs_fall = cyc;
        end
        if (vsync_n && !p_vs && t_vs_fall >= 0)
          chk("R8 vsync width", cyc - t_vs_fall, VS * LINE);
        if (eof) begin
          n_eof++;
          chk("R9 eof coincident", int'(!vsync_n && p_vs), 1);
        end
        if (p_eof) chk("R9 eof one clock", int'(eof), 0);
      end
      fresh = 0;
      p_hs = hsync_n; p_vs = vsync_n; p_hb = hblank; p_vb = vblank;
      p_ls = line_strobe; p_eof = eof; p_hp = hp; p_vp = vp;
    end
  end

  task automatic check_reset_state(input string tag);
    chk({tag, " hsync_n"}, int'(hsync_n), 1);
    chk({tag, " vsync_n"}, int'(vsync_n), 1);
    chk({tag, " hblank"}, int'(hblank), 0);
    chk({tag, " vblank"}, int'(vblank), 0);
    chk({tag, " h_pos"}, int'(h_pos), 0);
    chk({tag, " v_pos"}, int'(v_pos), 0);
    chk({tag, " line_strobe"}, int'(line_strobe), 0);
    chk({tag, " eof"}, int'(eof), 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    rst = 1'b1;
    clear_marks();
    #1;
    check_reset_state("R1 power-up");
    repeat (3) @(negedge clk);
    check_reset_state("R1 held");
    rst = 1'b0;
    mon_on = 1;
    repeat (5 * FRAME + 37) @(negedge clk);
    chk("R9 frames seen", int'(n_eof >= 4), 1);
    // Asynchronous reset in mid-frame, between clock edges
    #1 rst = 1'b1;
    mon_on = 0;
    #1;
    check_reset_state("R1 async");
    clear_marks();
    repeat (2) @(negedge clk);
    check_reset_state("R1 async held");
    rst = 1'b0;
    mon_on = 1;
    n_eof = 0;
    repeat (3 * FRAME + 11) @(negedge clk);
    chk("R9 frames after reset", int'(n_eof >= 2), 1);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      vec++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule